// File: doc/BRIEF.md
# Lighting Control Packet Transmitter

This block drives one serial line with a complete lighting control packet each time a start pulse arrives. A packet opens with a timed low period (the break) and then a timed high period (the mark after break). A fixed run of asynchronous slots follows. Each slot has one low start bit, eight data bits sent least significant bit first, and two high stop bits, with every bit lasting the same number of clocks.

A host fills a byte buffer through a simple write port and sets a slot count N. The first N slots of the packet carry the buffer bytes in index order. Every slot after those carries zero, so the packet length never changes. All durations are computed from the clock frequency, the baud rate and the break and mark times in microseconds. With the defaults (a 16 MHz clock, 250000 baud) the break is 1408 cycles, the mark is 128 cycles and a bit is 64 cycles.

Top module: `dmx_pkt_tx`

## Requirements
- R1: While reset is high, and on the first cycle after reset is released, `tx` is 1, `busy` is 0 and `done` is 0.
- R2: A `start` sampled high while idle drives `tx` low from the next cycle for exactly BREAK_CYC cycles (CLK_HZ/1e6 × BREAK_US).
- R3: After the break, `tx` is high for exactly MAB_CYC cycles (CLK_HZ/1e6 × MAB_US) before the first slot.
- R4: Each bit of a slot lasts BIT_CYC = CLK_HZ/BAUD cycles. A slot is a 0 start bit, then data bits 0 through 7 in that order, then two 1 stop bits.
- R5: Slots follow each other with no idle time. Every packet contains exactly TOTAL_SLOTS slots (258 by default).
- R6: Slot i carries buffer byte i when i < N, and carries 0x00 otherwise.
- R7: An N larger than TOTAL_SLOTS is treated as TOTAL_SLOTS, so the packet has no zero padding.
- R8: `busy` is high from the first break cycle through the last cycle of the final stop bit. On the cycle `busy` falls, `done` is high for exactly one cycle.
- R9: A `start` pulse while `busy` is high has no effect. The current packet is not restarted, and no second packet follows it.
- R10: A buffer write while `busy` is high is discarded. A write while idle to an address below TOTAL_SLOTS stores its byte.
- R11: `slot_count` is captured when a packet starts. Changes to it during the packet do not affect that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts one packet when sampled high while idle |
| slot_count | input | IDX_W | Number N of buffer slots to send |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | IDX_W | Buffer write index |
| wr_data | input | 8 | Buffer write byte |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle pulse at the end of a packet |
| tx | output | 1 | Serial output line, idles high |

## Verification
Two events can land in the same cycle as packet transmission: a new `start` pulse, and a buffer write together with a change of `slot_count`. The bench fires all of them part way through a packet that sends zero buffer slots. It then judges the result at the pins. The packet must finish unchanged, the line must stay idle afterwards, and the next packet's slot 0 must still carry the byte stored before the disturbed packet.

// File: rtl/dmx_pkt_tx.sv
module dmx_pkt_tx #(
  parameter int CLK_HZ      = 16_000_000,
  parameter int BAUD        = 250_000,
  parameter int BREAK_US    = 88,
  parameter int MAB_US      = 8,
  parameter int TOTAL_SLOTS = 258,
  parameter int IDX_W       = $clog2(TOTAL_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] slot_count,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  output logic             busy,
  output logic             done,
  output logic             tx
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int BIT_CYC    = CLK_HZ / BAUD;
  localparam int BREAK_CYC  = CYC_PER_US * BREAK_US;
  localparam int MAB_CYC    = CYC_PER_US * MAB_US;
  localparam int MAX_A      = (BREAK_CYC > MAB_CYC) ? BREAK_CYC : MAB_CYC;
  localparam int MAX_CYC    = (MAX_A > BIT_CYC) ? MAX_A : BIT_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);
  localparam int LAST_BIT   = 10;

  typedef enum logic [1:0] {S_IDLE, S_BRK, S_MAB, S_DATA} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [3:0]       bit_idx;
  logic [IDX_W-1:0] slot;
  logic [IDX_W-1:0] n_lat;
  logic [7:0]       mem [TOTAL_SLOTS];
  logic [7:0]       cur;
  logic             data_bit;
  logic             bit_end;

  assign busy     = (st != S_IDLE);
  assign cur      = (slot < n_lat) ? mem[slot] : 8'h00;
  assign data_bit = cur[bit_idx[2:0] - 3'd1];
  assign bit_end  = (cnt == CW'(BIT_CYC - 1));
  assign tx = (st == S_BRK)  ? 1'b0 :
              (st != S_DATA) ? 1'b1 :
              (bit_idx == 4'd0) ? 1'b0 :
              (bit_idx > 4'd8)  ? 1'b1 : data_bit;

  always_ff @(posedge clk) begin
    if (wr_en && !busy && (wr_addr < IDX_W'(TOTAL_SLOTS)))
      mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      slot    <= '0;
      n_lat   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_BRK;
          cnt   <= '0;
          n_lat <= (slot_count > IDX_W'(TOTAL_SLOTS)) ? IDX_W'(TOTAL_SLOTS) : slot_count;
        end
        S_BRK: if (cnt == CW'(BREAK_CYC - 1)) begin
          st  <= S_MAB;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_MAB: if (cnt == CW'(MAB_CYC - 1)) begin
          st      <= S_DATA;
          cnt     <= '0;
          bit_idx <= '0;
          slot    <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (bit_end) begin
          cnt <= '0;
          if (bit_idx == 4'(LAST_BIT)) begin
            bit_idx <= '0;
            if (slot == IDX_W'(TOTAL_SLOTS - 1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else slot <= slot + 1'b1;
          end else bit_idx <= bit_idx + 1'b1;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R2
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx);
  // R3
  mark_high_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_MAB) |-> tx);
  // R5
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA) |-> (slot < IDX_W'(TOTAL_SLOTS)));
  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == S_DATA) && (slot >= n_lat) && (bit_idx <= 4'd8)) |-> !tx);
  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (st == S_BRK)) |=> (st != S_IDLE));
endmodule

// File: tb/dmx_pkt_tx_bench.sv
module dmx_pkt_tx_bench;
  localparam int CLK_HZ = 4_000_000;
  localparam int BAUD   = 1_000_000;
  localparam int BIT    = CLK_HZ / BAUD;
  localparam int BRK    = (CLK_HZ / 1_000_000) * 88;
  localparam int MAB    = (CLK_HZ / 1_000_000) * 8;
  localparam int TOT    = 258;
  localparam int IW     = 9;

  logic clk = 0, rst = 1, start = 0, wr_en = 0;
  logic [IW-1:0] slot_count = '0, wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, done, tx;

  int vectors = 0, miscompares = 0, pkts = 0;
  byte unsigned model [TOT];
  byte unsigned expq [$];

  always #2 clk = ~clk;

  dmx_pkt_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .BREAK_US(88), .MAB_US(8),
               .TOTAL_SLOTS(TOT), .IDX_W(IW)) u_dmx_pkt_tx (
    .clk(clk), .rst(rst), .start(start), .slot_count(slot_count),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .tx(tx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input byte unsigned d);
    wr_en = 1; wr_addr = IW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(input int n, input bit disturb);
    int eff = (n > TOT) ? TOT : n;
    int target = pkts + 1;
    for (int i = 0; i < TOT; i++) expq.push_back(i < eff ? model[i] : 8'h00);
    slot_count = IW'(n);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R8 busy after start", busy, 1);
    if (disturb) begin
      repeat (600) @(negedge clk);
      start = 1; wr_en = 1; wr_addr = '0; wr_data = 8'hEE; slot_count = IW'(TOT);
      @(negedge clk);
      start = 0; wr_en = 0;
    end
    while (pkts != target) @(negedge clk);
    repeat (30) begin
      @(negedge clk);
      chk(tx == 1 && busy == 0, "R9 line idle after packet", {busy, tx}, 1);
    end
  endtask

  initial begin : monitor
    int lo, hi;
    byte unsigned got, exp;
    forever begin
      @(negedge clk);
      if (!rst && !tx) begin
        chk(busy == 1, "R8 busy during break", busy, 1);
        lo = 0;
        while (!tx) begin lo++; @(negedge clk); end
        chk(lo == BRK, "R2 break length", lo, BRK);
        hi = 0;
        while (tx) begin hi++; @(negedge clk); end
        chk(hi == MAB, "R3 mark length", hi, MAB);
        for (int s = 0; s < TOT; s++) begin
          repeat (BIT/2) @(negedge clk);
          chk(tx == 0, "R4 start bit", tx, 0);
          for (int b = 0; b < 8; b++) begin
            repeat (BIT) @(negedge clk);
            got[b] = tx;
          end
          repeat (BIT) @(negedge clk);
          chk(tx == 1, "R4 stop bit 1", tx, 1);
          repeat (BIT) @(negedge clk);
          chk(tx == 1, "R4 stop bit 2", tx, 1);
          exp = (expq.size() > 0) ? expq.pop_front() : 8'h00;
          chk(got == exp, "R6 slot byte", got, exp);
          repeat (BIT/2) @(negedge clk);
          if (s < TOT - 1)
            chk(tx == 0 && busy == 1, "R5 back-to-back slot", {busy, tx}, 2);
          else begin
            chk(busy == 0 && done == 1 && tx == 1, "R8 end of packet", {busy, done, tx}, 3);
            @(negedge clk);
            chk(done == 0, "R8 done single pulse", done, 0);
          end
        end
        pkts++;
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk(tx == 1 && busy == 0 && done == 0, "R1 in reset", {tx, busy, done}, 4);
    rst = 0;
    @(negedge clk);
    chk(tx == 1 && busy == 0 && done == 0, "R1 after reset", {tx, busy, done}, 4);
    for (int i = 0; i < TOT; i++) begin
      model[i] = byte'(i * 7 + 3);
      wr(i, model[i]);
    end
    send(5, 0);
    send(0, 1);    // R9 R10 R11 disturbed packet
    send(TOT, 0);  // R10 slot 0 keeps its old byte
    send(300, 0);  // R7
    model[0] = 8'h11; wr(0, 8'h11);
    model[256] = 8'h5A; wr(256, 8'h5A);
    send(257, 0);  // R6 one padding slot, R10 idle writes land
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", pkts, 5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule